// File: doc/BRIEF.md
# Maskable Two-Output Interrupt Router

This block collects interrupt sources into a sticky status register and gates each bit with a per-bit mask. It then steers every unmasked bit to one of two active-high interrupt lines that feed a microcontroller. Software works through a byte-wide register port. It polls and acknowledges sources in the status register, enables them in the mask register, and picks the target line for each source in the destination register.

The block also models the single interrupt line of an embedded bus-protocol core. Six event pulses can raise this line, and each event has its own enable bit. Five of these enable bits sit in a mode register and one sits in a select-enable register. A 3-bit cause code records the most recent enabled event. Software reads the cause code and then reads a dedicated clear address, which drops the line as a side effect of the read. The protocol engine, the DMA engine and the bus-phase logic are not part of this block. Their events arrive as single-cycle pulses.

Top module: `irq_steer_top`

## Requirements
- R1: After chip reset (rst_n low), all registers read 0, both microcontroller lines are low and the core line is low. In this state every source is masked and routed to line 0.
- R2: The status register at 0xFE0C reads back the sources seen so far.
  - A pulse on src_pulse[i] sets status bit i, even while bit i is masked.
  - Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
  - A pulse in the same cycle as a clearing write leaves the bit set.
- R3: In the mask register at 0xFE0D, bit value 0 keeps status bit i off both lines and bit value 1 lets it through.
- R4: In the destination register at 0xFE0E, bit value 0 sends source i to mcu_irq[0] and bit value 1 sends it to mcu_irq[1].
- R5: mcu_irq[n] is registered. At each edge it takes the OR, over all i, of status[i] & mask[i] & (dest[i]==n), using the register values held before that edge. A register change therefore shows on the lines one edge after it is written.
- R6: Each core_evt bit stands for one core event:
  - bit 0: selected or reselected
  - bit 1: DMA transfer end
  - bit 2: bus reset
  - bit 3: parity error
  - bit 4: phase mismatch
  - bit 5: disconnection
- R7: A DMA transfer end (core_evt[1]) counts as an event only when dma_rx_dir is 0 or dma_fifo_empty is 1. A receive with data still buffered is not reported.
- R8: Bit 0 of the select-enable register at 0xFC04 enables event 0. Bit k-1 of the mode register at 0xFC02 enables event k, for k = 1 to 5. A disabled event neither raises core_irq nor changes the cause code.
- R9: The bus-status register at 0xFC05 is read-only. It holds the cause code, which is 1 + the index of the lowest-numbered enabled event in the latest cycle that had one. The code is 0 after reset.
- R10: A read of 0xFC07 returns 0 and clears core_irq at that edge, unless an enabled event arrives in the same cycle, in which case core_irq stays high. Chip reset also clears core_irq.
- R11: bus_rdata is registered. It holds the value of the register addressed in the cycle bus_rd was high, as that value stood before the edge, and it keeps that value until the next read. Unmapped addresses read 0.
- R12: core_irq goes high at the edge that samples an enabled event and stays high until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| src_pulse | input | NSRC (8) | Single-cycle interrupt source pulses |
| core_evt | input | 6 | Single-cycle protocol-core event pulses |
| dma_rx_dir | input | 1 | Current DMA transfer is a receive |
| dma_fifo_empty | input | 1 | No data left buffered in the core |
| mcu_irq | output | 2 | Steered interrupt lines to the microcontroller |
| core_irq | output | 1 | Protocol-core interrupt line |

## Verification
A status bit is set at the edge that samples its pulse and reaches mcu_irq one edge after that. A mask or destination write also reaches mcu_irq one edge after the write edge. core_irq and the cause code change at the edge that samples the event or the clearing read. bus_rdata shows the value at the edge that samples bus_rd. The bench drives inputs and samples outputs on falling edges. Its reference model steps on the same rising edges as the design, so every comparison falls half a cycle after the edge at which each result is due. The directed checks wait the exact number of falling edges listed above, including an extra check between the edges that confirms a mask write is not yet visible.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int EVT_N  = 6;
  localparam int CODE_W = 3;

  // Cause code: 1 + index of the lowest-numbered set bit, 0 when none (R9)
  function automatic logic [CODE_W-1:0] cause_of(input logic [EVT_N-1:0] hits);
    logic [CODE_W-1:0] code;
    code = '0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (hits[i]) code = CODE_W'(i + 1);
    end
    return code;
  endfunction

  // New sticky status: set wins over write-one-to-clear (R2)
  function automatic logic [7:0] sticky_next(input logic [7:0] cur,
                                             input logic [7:0] clr,
                                             input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 8,
  parameter int NOUT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            wr_stat,
  input  logic            wr_mask,
  input  logic            wr_dest,
  input  logic [7:0]      wdata,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] dest_q,
  output logic [NOUT-1:0] irq_q
);
  import irq_steer_pkg::*;

  logic [7:0]      clr_vec;
  logic [7:0]      stat_ext;
  logic [7:0]      set_ext;
  logic [7:0]      stat_nx;
  logic [NSRC-1:0] live;

  assign clr_vec  = wr_stat ? wdata : 8'h00;
  assign stat_ext = 8'(status_q);
  assign set_ext  = 8'(src_pulse);
  assign stat_nx  = sticky_next(stat_ext, clr_vec, set_ext);
  assign live     = status_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      dest_q   <= '0;
    end else begin
      status_q <= stat_nx[NSRC-1:0];             // R2
      if (wr_mask) mask_q <= wdata[NSRC-1:0];    // R3
      if (wr_dest) dest_q <= wdata[NSRC-1:0];    // R4
    end
  end

  // One registered OR per output line (R5)
  for (genvar n = 0; n < NOUT; n++) begin : g_line
    logic [NSRC-1:0] pick;
    assign pick = (n == 0) ? ~dest_q : dest_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[n] <= 1'b0;
      else        irq_q[n] <= |(live & pick);
    end
  end
endmodule

// File: rtl/core_irq_unit.sv
module core_irq_unit
  import irq_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt,
  input  logic              dma_rx_dir,
  input  logic              dma_fifo_empty,
  input  logic              wr_mode,
  input  logic              wr_sel,
  input  logic [7:0]        wdata,
  input  logic              clr_rd,
  output logic [7:0]        mode_q,
  output logic [7:0]        sel_q,
  output logic [CODE_W-1:0] cause_q,
  output logic [EVT_N-1:0]  hits,
  output logic              line_q
);
  logic [EVT_N-1:0] enables;
  logic [EVT_N-1:0] qual;

  // R8: event 0 enabled by select-enable bit 0, events 1..5 by mode bits 0..4
  assign enables = {mode_q[EVT_N-2:0], sel_q[0]};

  // R7: a receive ends only once the buffer has drained
  always_comb begin
    qual    = evt;
    qual[1] = evt[1] & (~dma_rx_dir | dma_fifo_empty);
  end

  assign hits = qual & enables;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      sel_q   <= '0;
      cause_q <= '0;
      line_q  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_sel)  sel_q  <= wdata;
      if (|hits)   cause_q <= cause_of(hits);          // R9
      line_q <= (|hits) | (line_q & ~clr_rd);          // R10, R12
    end
  end
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top #(
  parameter int          NSRC       = 8,
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] A_STATUS   = 16'hFE0C,
  parameter logic [15:0] A_MASK     = 16'hFE0D,
  parameter logic [15:0] A_DEST     = 16'hFE0E,
  parameter logic [15:0] A_MODE     = 16'hFC02,
  parameter logic [15:0] A_SELEN    = 16'hFC04,
  parameter logic [15:0] A_CAUSE    = 16'hFC05,
  parameter logic [15:0] A_CLEAR    = 16'hFC07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NSRC-1:0]   src_pulse,
  input  logic [5:0]        core_evt,
  input  logic              dma_rx_dir,
  input  logic              dma_fifo_empty,
  output logic [1:0]        mcu_irq,
  output logic              core_irq
);
  import irq_steer_pkg::*;

  localparam int NOUT = 2;

  // Named internal wires, also used by the bound checker
  logic [NSRC-1:0]   status_w, mask_w, dest_w;
  logic [7:0]        mode_w, sel_w;
  logic [CODE_W-1:0] cause_w;
  logic [EVT_N-1:0]  hits_w;
  logic              clr_rd_w;
  logic              wr_stat, wr_mask, wr_dest, wr_mode, wr_sel;
  logic [7:0]        rd_mux;

  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(A_STATUS));
  assign wr_mask  = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign wr_dest  = bus_wr && (bus_addr == ADDR_W'(A_DEST));
  assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign wr_sel   = bus_wr && (bus_addr == ADDR_W'(A_SELEN));
  assign clr_rd_w = bus_rd && (bus_addr == ADDR_W'(A_CLEAR));

  irq_src_bank #(.NSRC(NSRC), .NOUT(NOUT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_pulse(src_pulse),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .wr_dest  (wr_dest),
    .wdata    (bus_wdata),
    .status_q (status_w),
    .mask_q   (mask_w),
    .dest_q   (dest_w),
    .irq_q    (mcu_irq)
  );

  core_irq_unit u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt           (core_evt),
    .dma_rx_dir    (dma_rx_dir),
    .dma_fifo_empty(dma_fifo_empty),
    .wr_mode       (wr_mode),
    .wr_sel        (wr_sel),
    .wdata         (bus_wdata),
    .clr_rd        (clr_rd_w),
    .mode_q        (mode_w),
    .sel_q         (sel_w),
    .cause_q       (cause_w),
    .hits          (hits_w),
    .line_q        (core_irq)
  );

  // R11: read mux over pre-edge register values; clear address and holes read 0
  always_comb begin
    rd_mux = 8'h00;
    if      (bus_addr == ADDR_W'(A_STATUS)) rd_mux = 8'(status_w);
    else if (bus_addr == ADDR_W'(A_MASK))   rd_mux = 8'(mask_w);
    else if (bus_addr == ADDR_W'(A_DEST))   rd_mux = 8'(dest_w);
    else if (bus_addr == ADDR_W'(A_MODE))   rd_mux = mode_w;
    else if (bus_addr == ADDR_W'(A_SELEN))  rd_mux = sel_w;
    else if (bus_addr == ADDR_W'(A_CAUSE))  rd_mux = 8'(cause_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_pulse,
  input logic [NSRC-1:0] status_w,
  input logic [NSRC-1:0] mask_w,
  input logic [1:0]      mcu_irq,
  input logic [5:0]      hits_w,
  input logic [2:0]      cause_w,
  input logic            clr_rd_w,
  input logic            core_irq
);
  a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((status_w & $past(src_pulse)) == $past(src_pulse)));

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |=> (mcu_irq == 2'b00));

  a_r12_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits_w) |=> core_irq);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd_w && !(|hits_w)) |=> !core_irq);

  a_r10_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && !clr_rd_w) |=> core_irq);

  a_r9_code_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits_w) |=> (cause_w != 3'd0 && cause_w <= 3'd6));
endmodule

bind irq_steer_top irq_steer_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_pulse(src_pulse),
  .status_w (status_w),
  .mask_w   (mask_w),
  .mcu_irq  (mcu_irq),
  .hits_w   (hits_w),
  .cause_w  (cause_w),
  .clr_rd_w (clr_rd_w),
  .core_irq (core_irq)
);

// File: tb/sim_irq_steer_top.sv
`timescale 1ns/1ps
module sim_irq_steer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  src_pulse = '0;
  logic [5:0]  core_evt = '0;
  logic        dma_rx_dir = 1'b0, dma_fifo_empty = 1'b1;
  logic [1:0]  mcu_irq;
  logic        core_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  irq_steer_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
    .core_evt(core_evt), .dma_rx_dir(dma_rx_dir), .dma_fifo_empty(dma_fifo_empty),
    .mcu_irq(mcu_irq), .core_irq(core_irq)
  );

  // Behavioural reference model, stepped on the same rising edges
  logic [7:0] m_stat, m_mask, m_dest, m_mode, m_sel, m_rdata;
  logic [2:0] m_code;
  logic       m_line;
  logic [1:0] m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 0; m_mask <= 0; m_dest <= 0; m_mode <= 0; m_sel <= 0;
      m_rdata <= 0; m_code <= 0; m_line <= 0; m_irq <= 0;
    end else begin
      logic [5:0] en, ev;
      logic [7:0] rv;
      logic [2:0] c;
      logic       any0, any1;
      en = {m_mode[4:0], m_sel[0]};
      ev = core_evt & en;
      if (dma_rx_dir && !dma_fifo_empty) ev[1] = 1'b0;
      c = 0;
      for (int i = 5; i >= 0; i--) if (ev[i]) c = 3'(i + 1);
      any0 = 0; any1 = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_stat[i] && m_mask[i] && !m_dest[i]) any0 = 1;
        if (m_stat[i] && m_mask[i] &&  m_dest[i]) any1 = 1;
      end
      m_irq <= {any1, any0};
      case (bus_addr)
        16'hFE0C: rv = m_stat;
        16'hFE0D: rv = m_mask;
        16'hFE0E: rv = m_dest;
        16'hFC02: rv = m_mode;
        16'hFC04: rv = m_sel;
        16'hFC05: rv = {5'd0, m_code};
        default:  rv = 0;
      endcase
      if (bus_rd) m_rdata <= rv;
      if (bus_wr && bus_addr == 16'hFE0C) m_stat <= (m_stat & ~bus_wdata) | src_pulse;
      else                                 m_stat <= m_stat | src_pulse;
      if (bus_wr && bus_addr == 16'hFE0D) m_mask <= bus_wdata;
      if (bus_wr && bus_addr == 16'hFE0E) m_dest <= bus_wdata;
      if (bus_wr && bus_addr == 16'hFC02) m_mode <= bus_wdata;
      if (bus_wr && bus_addr == 16'hFC04) m_sel  <= bus_wdata;
      if (ev != 0) m_code <= c;
      if (ev != 0) m_line <= 1'b1;
      else if (bus_rd && bus_addr == 16'hFC07) m_line <= 1'b0;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 mcu_irq vs model", mcu_irq, m_irq);
      check("R12 core_irq vs model", core_irq, m_line);
      check("R11 bus_rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [5:0] e);
    @(negedge clk); src_pulse = s; core_evt = e;
    @(negedge clk); src_pulse = 0; core_evt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    idle(3);
    check("R1 mcu_irq in reset", mcu_irq, 0);
    check("R1 core_irq in reset", core_irq, 0);
    @(negedge clk); rst_n = 1;
    rd(16'hFE0C, d); check("R1 status after reset", d, 0);
    rd(16'hFE0E, d); check("R1 dest after reset", d, 0);

    pulse(8'h08, 0);
    rd(16'hFE0C, d); check("R2 sticky status while masked", d, 8'h08);
    check("R3 masked source quiet", mcu_irq, 0);

    wr(16'hFE0D, 8'h08);
    check("R5 mask write not yet visible", mcu_irq, 0);
    @(negedge clk); check("R4 dest 0 to line 0", mcu_irq, 2'b01);

    wr(16'hFE0E, 8'h08); idle(1);
    check("R4 dest 1 to line 1", mcu_irq, 2'b10);

    wr(16'hFE0C, 8'h08); idle(1);
    check("R2 write one clears line", mcu_irq, 0);
    rd(16'hFE0C, d); check("R2 status cleared", d, 0);

    @(negedge clk); bus_addr = 16'hFE0C; bus_wdata = 8'h04; bus_wr = 1; src_pulse = 8'h04;
    @(negedge clk); bus_wr = 0; src_pulse = 0;
    rd(16'hFE0C, d); check("R2 pulse beats clear", d, 8'h04);

    pulse(0, 6'h3F);
    check("R8 disabled events ignored", core_irq, 0);
    rd(16'hFC05, d); check("R8 code unchanged when disabled", d, 0);

    wr(16'hFC04, 8'h01);
    pulse(0, 6'h01);
    check("R12 select raises line", core_irq, 1);
    rd(16'hFC05, d); check("R9 code for select", d, 1);

    rd(16'hFC07, d);
    check("R10 clearing read drops line", core_irq, 0);
    check("R11 clear address reads 0", d, 0);

    wr(16'hFC02, 8'h1F);
    pulse(0, 6'h28);
    check("R6 parity and disconnect raise line", core_irq, 1);
    rd(16'hFC05, d); check("R9 lowest index wins", d, 4);

    @(negedge clk); bus_addr = 16'hFC07; bus_rd = 1; core_evt = 6'h04;
    @(negedge clk); bus_rd = 0; core_evt = 0;
    check("R10 event beats clearing read", core_irq, 1);
    rd(16'hFC05, d); check("R9 code for bus reset", d, 3);

    rd(16'hFC07, d);
    dma_rx_dir = 1; dma_fifo_empty = 0;
    pulse(0, 6'h02);
    check("R7 receive with data buffered ignored", core_irq, 0);
    dma_fifo_empty = 1;
    pulse(0, 6'h02);
    check("R7 drained receive raises line", core_irq, 1);
    rd(16'hFC05, d); check("R9 code for DMA end", d, 2);
    dma_rx_dir = 0;

    rd(16'h1234, d); check("R11 unmapped reads 0", d, 0);
    rd(16'hFC02, d); check("R11 mode readback", d, 8'h1F);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R10 chip reset clears core_irq", core_irq, 0);
    check("R1 reset clears lines", mcu_irq, 0);
    rst_n = 1;
    rd(16'hFE0C, d); check("R1 status zero after reset", d, 0);
    idle(2);
    finish_run();
  end
endmodule